// File: doc/BRIEF.md
# Packet Transmit Adapter with Fixed Ready Latency

This block connects an application packet source to a transmit sink. The source side uses a plain valid/ready handshake with no latency: a beat moves on any clock edge where both valid and ready are high. The sink side works on credit with a fixed delay. A beat may be shown to the sink only in the cycle that comes a fixed number of cycles (three by default) after a cycle in which the sink's ready was high. Each beat is 256 bits wide. It carries start and end markers, a nullify flag and a 2-bit count of unused 64-bit qwords.

An internal FIFO sits between the two sides. The source-side ready is cut early enough that beats already in flight are never lost. Sink outputs come straight from registers, and beat order is kept exactly.

The block also checks packet framing as beats go through. A nullify flag on a beat that is not the end beat is moved to that packet's end beat. The empty count is cleared on every beat that is not an end beat. Framing errors set a sticky status bit, and the beat itself passes through unchanged. A packet that is a single beat carrying start, end and nullify together is forwarded, and it is also counted as dropped.

Top module: `pkt_tx_latency_adapter`

## Requirements
- R1: While rst_n is low (a synchronous reset) and in the first cycle after it, snk_valid is 0, src_ready is 1, frame_viol is 0 and drop_count is 0.
- R2: snk_valid is high in cycle t only if snk_ready was high in cycle t-RDY_LAT (default 3).
- R3: src_ready is low whenever fewer than RDY_LAT+1 FIFO entries are free. With DEPTH=8, RDY_LAT=3 and the sink never ready, exactly 5 beats are accepted before src_ready drops.
- R4: Every accepted beat reaches the sink exactly once, in the order it was accepted, with its data, start flag (snk_sop) and end flag (snk_eop) unchanged.
- R5: snk_err is high only on a beat with snk_eop high. On an end beat it is high if the nullify flag was set on that beat, or on any earlier beat of the same packet.
- R6: snk_empty equals src_empty on end beats and is 0 on every other beat.
- R7: A nullify flag on a beat without src_eop sets frame_viol, and frame_viol stays high until reset. Well-formed traffic leaves frame_viol at 0.
- R8: A src_sop that arrives while a packet is open sets frame_viol. That beat is forwarded unchanged and begins a new packet.
- R9: A src_eop on a beat without src_sop while no packet is open sets frame_viol, and the beat is forwarded unchanged.
- R10: A beat with src_sop, src_eop and src_err all high is forwarded with snk_err high and adds one to drop_count. Multi-beat nullified packets leave drop_count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_valid | input | 1 | Source beat valid |
| src_ready | output | 1 | Adapter can take a beat this cycle |
| src_data | input | 256 | Source beat payload |
| src_sop | input | 1 | First beat of a packet |
| src_eop | input | 1 | Last beat of a packet |
| src_err | input | 1 | Nullify the current packet |
| src_empty | input | 2 | Unused qwords in the last beat |
| snk_ready | input | 1 | Sink credit, acts RDY_LAT cycles later |
| snk_valid | output | 1 | Beat to sink valid |
| snk_data | output | 256 | Beat payload to sink |
| snk_sop | output | 1 | First beat marker to sink |
| snk_eop | output | 1 | Last beat marker to sink |
| snk_err | output | 1 | Nullify marker, end beat only |
| snk_empty | output | 2 | Unused qwords, end beat only |
| frame_viol | output | 1 | Sticky framing-violation status |
| drop_count | output | CNT_W | Number of single-beat nullified packets |

## Verification
The hardest state to reach is a full FIFO with sink credits still arriving. Beats granted before the sink's ready fell must still be in the pipeline when the source-side ready drops. The bench first runs the sink with no credit until the history is empty. It then holds the source valid steadily, which fills the FIFO to exactly its cut-off level. Next it releases the sink into a pseudo-random credit pattern, so that pops, pushes and the latency window overlap. A sink model checks every valid beat against the credit it gave RDY_LAT cycles earlier.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;
   localparam int BEAT_W      = 256;
   localparam int QW_PER_BEAT = BEAT_W / 64;
   localparam int EMPTY_W     = $clog2(QW_PER_BEAT);

   typedef struct packed {
      logic [BEAT_W-1:0]  data;
      logic               sop;
      logic               eop;
      logic               err;
      logic [EMPTY_W-1:0] empty;
   } beat_t;
endpackage

// File: rtl/pkt_tx_framer.sv
module pkt_tx_framer
   import pkt_tx_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_fire,
   input  beat_t            in_beat,
   output beat_t            out_beat,
   output logic             viol,
   output logic [CNT_W-1:0] drops
);
   logic open_q, pend_q, viol_q;
   logic [CNT_W-1:0] drop_q;
   logic pend_eff, viol_now, lone_null;

   always_comb begin
      pend_eff       = in_beat.sop ? 1'b0 : pend_q;
      out_beat       = in_beat;
      out_beat.err   = in_beat.eop & (in_beat.err | pend_eff);
      out_beat.empty = in_beat.eop ? in_beat.empty : '0;
      viol_now = in_fire & ((in_beat.sop & open_q) |
                            (in_beat.eop & ~in_beat.sop & ~open_q) |
                            (in_beat.err & ~in_beat.eop));
      lone_null = in_fire & in_beat.sop & in_beat.eop & in_beat.err;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         pend_q <= 1'b0;
         viol_q <= 1'b0;
         drop_q <= '0;
      end else begin
         if (viol_now) viol_q <= 1'b1;
         if (lone_null) drop_q <= drop_q + 1'b1;
         if (in_fire) begin
            open_q <= ~in_beat.eop & (in_beat.sop | open_q);
            pend_q <= ~in_beat.eop & (pend_eff | in_beat.err);
         end
      end
   end

   assign viol  = viol_q;
   assign drops = drop_q;

   p_viol_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      viol_q |=> viol_q);
   p_carry_to_eop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_fire && in_beat.err && !in_beat.eop) |=> pend_q);
endmodule

// File: rtl/pkt_tx_fifo.sv
module pkt_tx_fifo
   import pkt_tx_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  beat_t         push_beat,
   input  logic          pop,
   output beat_t         pop_beat,
   output logic [CW-1:0] count
);
   beat_t mem [DEPTH];
   logic [AW-1:0] wr_q, rd_q, wr_nx, rd_nx;
   logic [CW-1:0] cnt_q;

   if (DEPTH < 4) begin : g_depth_bad
      $error("pkt_tx_fifo: DEPTH must be at least 4");
   end

   if ((1 << AW) == DEPTH) begin : g_pow2
      assign wr_nx = wr_q + 1'b1;
      assign rd_nx = rd_q + 1'b1;
   end else begin : g_wrap
      assign wr_nx = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      assign rd_nx = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (push) mem[wr_q] <= push_beat;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wr_q <= wr_nx;
         if (pop)  rd_q <= rd_nx;
         if (push && !pop)      cnt_q <= cnt_q + 1'b1;
         else if (pop && !push) cnt_q <= cnt_q - 1'b1;
      end
   end

   assign pop_beat = mem[rd_q];
   assign count    = cnt_q;

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (cnt_q < CW'(DEPTH)));
   p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (cnt_q != '0));
endmodule

// File: rtl/pkt_tx_credit.sv
module pkt_tx_credit #(
   parameter int RDY_LAT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic snk_ready,
   output logic grant
);
   if (RDY_LAT < 2) begin : g_lat_bad
      $error("pkt_tx_credit: RDY_LAT must be at least 2");
   end

   if (RDY_LAT == 2) begin : g_single
      logic hist_q;
      always_ff @(posedge clk) begin
         if (!rst_n) hist_q <= 1'b0;
         else        hist_q <= snk_ready;
      end
      assign grant = hist_q;
   end else begin : g_chain
      logic [RDY_LAT-2:0] hist_q;
      always_ff @(posedge clk) begin
         if (!rst_n) hist_q <= '0;
         else        hist_q <= {hist_q[RDY_LAT-3:0], snk_ready};
      end
      assign grant = hist_q[RDY_LAT-2];
   end
endmodule

// File: rtl/pkt_tx_latency_adapter.sv
module pkt_tx_latency_adapter
   import pkt_tx_pkg::*;
#(
   parameter int DEPTH   = 8,
   parameter int RDY_LAT = 3,
   parameter int CNT_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               src_valid,
   output logic               src_ready,
   input  logic [BEAT_W-1:0]  src_data,
   input  logic               src_sop,
   input  logic               src_eop,
   input  logic               src_err,
   input  logic [EMPTY_W-1:0] src_empty,
   input  logic               snk_ready,
   output logic               snk_valid,
   output logic [BEAT_W-1:0]  snk_data,
   output logic               snk_sop,
   output logic               snk_eop,
   output logic               snk_err,
   output logic [EMPTY_W-1:0] snk_empty,
   output logic               frame_viol,
   output logic [CNT_W-1:0]   drop_count
);
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < RDY_LAT + 1) begin : g_room_bad
      $error("pkt_tx_latency_adapter: DEPTH must be at least RDY_LAT+1");
   end

   beat_t in_beat, fr_beat, head_beat, out_q;
   logic [CW-1:0] count, free;
   logic src_fire, grant, pop, vld_q;

   assign in_beat = '{data: src_data, sop: src_sop, eop: src_eop,
                      err: src_err, empty: src_empty};
   assign free      = CW'(DEPTH) - count;
   assign src_ready = (free >= CW'(RDY_LAT + 1));
   assign src_fire  = src_valid & src_ready;

   pkt_tx_framer #(.CNT_W(CNT_W)) u_framer (
      .clk(clk), .rst_n(rst_n), .in_fire(src_fire), .in_beat(in_beat),
      .out_beat(fr_beat), .viol(frame_viol), .drops(drop_count));

   pkt_tx_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(src_fire), .push_beat(fr_beat),
      .pop(pop), .pop_beat(head_beat), .count(count));

   pkt_tx_credit #(.RDY_LAT(RDY_LAT)) u_credit (
      .clk(clk), .rst_n(rst_n), .snk_ready(snk_ready), .grant(grant));

   assign pop = grant & (count != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         out_q <= '0;
      end else begin
         vld_q <= pop;
         if (pop) out_q <= head_beat;
      end
   end

   assign snk_valid = vld_q;
   assign snk_data  = out_q.data;
   assign snk_sop   = out_q.sop;
   assign snk_eop   = out_q.eop;
   assign snk_err   = out_q.err;
   assign snk_empty = out_q.empty;

   // Independent record of sink credit for checking the latency rule.
   logic [RDY_LAT-1:0] chk_rdy;
   always_ff @(posedge clk) begin
      if (!rst_n) chk_rdy <= '0;
      else        chk_rdy <= {chk_rdy[RDY_LAT-2:0], snk_ready};
   end

   p_sink_credit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      snk_valid |-> chk_rdy[RDY_LAT-1]);
   p_err_on_eop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (snk_valid && snk_err) |-> snk_eop);
   p_empty_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (snk_valid && !snk_eop) |-> (snk_empty == '0));
   p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (count > CW'(DEPTH - RDY_LAT - 1)) |-> !src_ready);
endmodule

// File: tb/test_pkt_tx_latency_adapter.sv
`timescale 1ns/1ps
module test_pkt_tx_latency_adapter;
   localparam int DEPTH = 8, LAT = 3;
   localparam real CLK_NS = 4.0;

   logic clk = 1'b0, rst_n = 1'b0;
   logic src_valid = 1'b0, src_sop = 1'b0, src_eop = 1'b0, src_err = 1'b0;
   logic [255:0] src_data = '0;
   logic [1:0] src_empty = '0;
   logic src_ready, snk_ready, snk_valid, snk_sop, snk_eop, snk_err, frame_viol;
   logic [255:0] snk_data;
   logic [1:0] snk_empty;
   logic [15:0] drop_count;

   pkt_tx_latency_adapter i_pkt_tx_latency_adapter (.*);

   always #(CLK_NS/2) clk = ~clk;

   int vectors = 0, miscompares = 0;
   int wr_i = 0, rd_i = 0, mode = 0, cyc = 0;
   logic [255:0] e_data [0:511];
   logic e_sop [0:511], e_eop [0:511], e_err [0:511];
   logic [1:0] e_empty [0:511];
   logic [LAT-1:0] rh = '0;
   logic [15:0] lfsr = 16'hACE1;
   logic [31:0] seq = 32'h1000;

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Sink model: checks credit rule and beat contents, then drives ready.
   always @(negedge clk) begin
      logic nr;
      cyc++;
      if (!rst_n) begin
         rh = '0;
         snk_ready = 1'b0;
      end else begin
         if (snk_valid) begin
            check(rh[LAT-1], "R2 credit", 1, rh[LAT-1]);
            check(snk_data == e_data[rd_i] && snk_sop == e_sop[rd_i] &&
                  snk_eop == e_eop[rd_i], "R4 beat", snk_data[63:0],
                  e_data[rd_i][63:0]);
            check(snk_err == e_err[rd_i], "R5 err", snk_err, e_err[rd_i]);
            check(snk_empty == e_empty[rd_i], "R6 empty", snk_empty,
                  e_empty[rd_i]);
            rd_i++;
         end
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         case (mode)
            0: nr = 1'b1;
            1: nr = 1'b0;
            2: nr = (cyc % 3) != 0;
            default: nr = lfsr[0] | lfsr[5];
         endcase
         snk_ready = nr;
         rh = {rh[LAT-2:0], nr};
      end
   end

   task automatic push_exp(input logic [255:0] d, input logic s, e, er,
                           input logic [1:0] em);
      e_data[wr_i] = d; e_sop[wr_i] = s; e_eop[wr_i] = e;
      e_err[wr_i] = er; e_empty[wr_i] = em;
      wr_i++;
   endtask

   task automatic send(input logic s, e, er, input logic [1:0] em,
                       input logic x_er, input logic [1:0] x_em);
      seq++;
      src_data = {8{seq}}; src_sop = s; src_eop = e; src_err = er;
      src_empty = em; src_valid = 1'b1;
      while (!src_ready) @(negedge clk);
      push_exp({8{seq}}, s, e, x_er, x_em);
      @(negedge clk);
      src_valid = 1'b0;
   endtask

   task automatic drain(input string req);
      for (int i = 0; i < 300 && rd_i != wr_i; i++) @(negedge clk);
      repeat (4) @(negedge clk);
      check(rd_i == wr_i, req, rd_i, wr_i);
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 1'b0; src_valid = 1'b0;
      repeat (3) @(negedge clk);
      wr_i = 0; rd_i = 0;
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();   // R1
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(snk_valid == 1'b0 && src_ready == 1'b1, "R1 handshake in reset",
            {snk_valid, src_ready}, 2'b01);
      rst_n = 1'b1;
      @(negedge clk);
      check(snk_valid == 1'b0 && src_ready == 1'b1, "R1 handshake",
            {snk_valid, src_ready}, 2'b01);
      check(frame_viol == 1'b0 && drop_count == 0, "R1 status",
            {frame_viol, drop_count}, 0);
   endtask

   task automatic t_stream();  // R4 R6 R2 R7
      mode = 3;
      for (int p = 0; p < 16; p++) begin
         int len = (p % 4) + 1;
         for (int b = 0; b < len; b++) begin
            logic last = (b == len - 1);
            send(b == 0, last, 1'b0, 2'd3, 1'b0, last ? 2'd3 : 2'd0);
         end
      end
      drain("R4 stream count");
      check(frame_viol == 1'b0, "R7 clean traffic", frame_viol, 0);
      mode = 2;
      for (int b = 0; b < 10; b++) send(1'b1, 1'b1, 1'b0, 2'(b), 1'b0, 2'(b));
      drain("R2 periodic credit count");
   endtask

   task automatic t_backpressure();  // R3
      int acc = 0;
      mode = 1;
      repeat (6) @(negedge clk);
      src_valid = 1'b1; src_sop = 1'b1; src_eop = 1'b1; src_err = 1'b0;
      src_empty = 2'd1;
      for (int i = 0; i < 12; i++) begin
         seq++;
         src_data = {8{seq}};
         if (src_ready) begin
            acc++;
            push_exp({8{seq}}, 1'b1, 1'b1, 1'b0, 2'd1);
         end
         @(negedge clk);
      end
      check(acc == DEPTH - LAT, "R3 accepted beats", acc, DEPTH - LAT);
      check(src_ready == 1'b0, "R3 ready low when full", src_ready, 0);
      src_valid = 1'b0;
      mode = 3;
      drain("R3 no beat lost");
      mode = 0;
   endtask

   task automatic t_err();  // R5 R7
      apply_reset();
      send(1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0);
      send(1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0);
      send(1'b0, 1'b1, 1'b1, 2'd2, 1'b1, 2'd2);
      drain("R5 err on eop");
      check(frame_viol == 1'b0, "R7 legal err", frame_viol, 0);
      send(1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0);
      send(1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 2'd0);
      send(1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0);
      send(1'b0, 1'b1, 1'b0, 2'd1, 1'b1, 2'd1);
      drain("R5 carried err");
      check(frame_viol == 1'b1, "R7 early err flagged", frame_viol, 1);
      send(1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0);
      drain("R7 sticky traffic");
      check(frame_viol == 1'b1, "R7 sticky", frame_viol, 1);
   endtask

   task automatic t_sop_open();  // R8
      apply_reset();
      send(1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0);
      send(1'b1, 1'b0, 1'b0, 2'd3, 1'b0, 2'd0);
      send(1'b0, 1'b1, 1'b0, 2'd3, 1'b0, 2'd3);
      drain("R8 passthrough");
      check(frame_viol == 1'b1, "R8 sop while open", frame_viol, 1);
   endtask

   task automatic t_orphan_eop();  // R9
      apply_reset();
      send(1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0);
      check(frame_viol == 1'b0, "R9 before orphan", frame_viol, 0);
      send(1'b0, 1'b1, 1'b0, 2'd2, 1'b0, 2'd2);
      drain("R9 passthrough");
      check(frame_viol == 1'b1, "R9 orphan eop", frame_viol, 1);
   endtask

   task automatic t_drop();  // R10
      apply_reset();
      send(1'b1, 1'b1, 1'b1, 2'd2, 1'b1, 2'd2);
      drain("R10 forwarded");
      check(drop_count == 1, "R10 counted", drop_count, 1);
      send(1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0);
      send(1'b0, 1'b1, 1'b1, 2'd0, 1'b1, 2'd0);
      drain("R10 multi-beat forwarded");
      check(drop_count == 1, "R10 multi-beat not counted", drop_count, 1);
      check(frame_viol == 1'b0, "R10 no violation", frame_viol, 0);
   endtask

   initial begin
      #(CLK_NS * 150000);
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_stream();
      t_backpressure();
      t_err();
      t_sop_open();
      t_orphan_eop();
      t_drop();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule